// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Controller

This block sits between a clocked internal bus and a pseudo-static RAM used in its power-up asynchronous mode. A single-word read or write request is taken from the bus side. It becomes an SRAM-style strobe sequence on chip enable, output enable, write enable and two active-low byte selects. The memory data bus is a shared tri-state bus. Read data is captured once a programmable number of clocks has passed. A one-clock ready pulse ends every request.

The memory refreshes itself while chip enable is high, so chip enable must not stay low for too long. Access lengths are parameters in clock cycles. Any set of parameters that would hold chip enable low beyond the allowed count is rejected at elaboration. Each access is one word, so no request is ever split. Strobes rise together at the end of a write, and write data stays on the bus one clock after that. All strobes stay high between accesses.

Top module: `psram_async_ctrl`

## Requirements
- R1: After reset, every memory strobe (mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n) is high, the controller does not drive mem_dq, and rsp_ready is low.
- R2: A read holds mem_ce_n, mem_oe_n and the selected byte selects low, with mem_we_n high, for exactly RD_CYC clocks. It starts the clock after the request is accepted, and mem_addr holds the request address throughout.
- R3: Read data is sampled from mem_dq at the clock edge that ends the RD_CYC-clock strobe window. It appears on rsp_rdata together with a rsp_ready pulse in the following clock.
- R4: A write holds mem_ce_n, mem_we_n and the selected byte selects low, with mem_oe_n high, for exactly WR_CYC clocks, starting the clock after acceptance.
- R5: Write data is driven on mem_dq for the whole write strobe window and for one further clock after all strobes rise together. rsp_ready pulses in the clock after that.
- R6: mem_ce_n is never low for more than CE_MAX_CYC consecutive clocks. Parameters with RD_CYC or WR_CYC above CE_MAX_CYC fail elaboration.
- R7: req_be bits are active-high lane enables. req_be[1] drives mem_ub_n and covers data bits 15:8, and req_be[0] drives mem_lb_n and covers bits 7:0. A disabled lane's select stays high, and its byte of rsp_rdata is zero after a read.
- R8: A request with req_be equal to 2'b00 produces no strobe activity and no memory write, and rsp_ready pulses in the clock after acceptance.
- R9: The controller drives mem_dq only in write cycles, and never in the clock in which mem_oe_n goes low or the one before it.
- R10: rsp_ready is high for exactly one clock per request. Requests are accepted only in the idle state, and request inputs changed while busy have no effect. All strobes stay high for at least one clock between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when the controller is idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Active-high byte lane enables |
| rsp_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_ready after a read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_addr | output | 22 | Memory word address |
| mem_dq | inout | 16 | Shared memory data bus |

## Verification
Take the accepting clock edge as edge 0. The read strobes are visible after edge 0 and read data with ready after edge RD_CYC. Write strobes fall after edge 0 and rise after edge WR_CYC, and ready follows after edge WR_CYC+1. A request with no enabled lane gives ready after edge 0. The bench model counts edges since acceptance and predicts every strobe, address, bus value and ready level for the current clock. It compares them at the falling clock edge, half a period away from the edge that updates the registers. Its memory model returns a poison value until output enable has been low for RD_CYC clocks, so a capture made too early shows up as a data mismatch.

// File: rtl/psram_pkg.sv
package psram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_WRITE = 3'd2,
      ST_HOLD  = 3'd3,
      ST_GAP   = 3'd4
   } seq_state_t;

endpackage

// File: rtl/psram_seq.sv
module psram_seq
   import psram_pkg::*;
#(
   parameter int RD_CYC     = 4,
   parameter int WR_CYC     = 3,
   parameter int CE_MAX_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_we,
   input  logic req_any,
   output logic load,
   output logic drop_strb,
   output logic capture,
   output logic ce_n,
   output logic oe_n,
   output logic we_n,
   output logic dq_oe,
   output logic rdy
);

   localparam int MAXC  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam int RUN_W = $clog2(CE_MAX_CYC + 2);

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic             accept;
   logic             rd_last;
   logic             wr_last;

   assign accept    = (state == ST_IDLE) && req_valid;
   assign load      = accept && req_any;
   assign rd_last   = (state == ST_READ)  && (cnt == CNT_W'(RD_CYC - 1));
   assign wr_last   = (state == ST_WRITE) && (cnt == CNT_W'(WR_CYC - 1));
   assign drop_strb = rd_last || wr_last;
   assign capture   = rd_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
         rdy   <= 1'b0;
      end else begin
         rdy <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (accept) begin
                  if (!req_any) begin
                     rdy   <= 1'b1;
                     state <= ST_GAP;
                  end else if (req_we) begin
                     ce_n  <= 1'b0;
                     we_n  <= 1'b0;
                     dq_oe <= 1'b1;
                     state <= ST_WRITE;
                  end else begin
                     ce_n  <= 1'b0;
                     oe_n  <= 1'b0;
                     state <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               cnt <= cnt + CNT_W'(1);
               if (rd_last) begin
                  ce_n  <= 1'b1;
                  oe_n  <= 1'b1;
                  rdy   <= 1'b1;
                  state <= ST_GAP;
               end
            end
            ST_WRITE: begin
               cnt <= cnt + CNT_W'(1);
               if (wr_last) begin
                  ce_n  <= 1'b1;
                  we_n  <= 1'b1;
                  state <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               dq_oe <= 1'b0;
               rdy   <= 1'b1;
               state <= ST_GAP;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // checker counter: consecutive clocks with chip enable low
   logic [RUN_W-1:0] ce_run;
   always_ff @(posedge clk) begin
      if (!rst_n)                               ce_run <= '0;
      else if (ce_n)                            ce_run <= '0;
      else if (ce_run != RUN_W'(CE_MAX_CYC + 1)) ce_run <= ce_run + RUN_W'(1);
   end

   p_ce_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ce_run <= RUN_W'(CE_MAX_CYC));
   p_rd_no_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> we_n);
   p_wr_oe_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> oe_n);
   p_rdy_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |=> !rdy);
   p_gap_after_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce_n) |=> ce_n);

endmodule

// File: rtl/psram_lane.sv
module psram_lane #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              drop_strb,
   input  logic              capture,
   input  logic              sel_in,
   input  logic [BYTE_W-1:0] wbyte_in,
   input  logic [BYTE_W-1:0] dq_in,
   output logic              strb_n,
   output logic [BYTE_W-1:0] wbyte,
   output logic [BYTE_W-1:0] rbyte
);

   logic sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strb_n <= 1'b1;
         sel_q  <= 1'b0;
         wbyte  <= '0;
         rbyte  <= '0;
      end else begin
         if (load) begin
            strb_n <= ~sel_in;
            sel_q  <= sel_in;
            wbyte  <= wbyte_in;
         end else if (drop_strb) begin
            strb_n <= 1'b1;
         end
         if (capture) rbyte <= sel_q ? dq_in : '0;
      end
   end

   p_lane_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_n |-> sel_q);

endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl #(
   parameter int ADDR_W     = 22,
   parameter int DATA_W     = 16,
   parameter int BYTE_W     = 8,
   parameter int RD_CYC     = 4,
   parameter int WR_CYC     = 3,
   parameter int CE_MAX_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_be,
   output logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_ub_n,
   output logic              mem_lb_n,
   output logic [ADDR_W-1:0] mem_addr,
   inout  wire  [DATA_W-1:0] mem_dq
);

   localparam int LANES = DATA_W / BYTE_W;

   if (DATA_W != 2 * BYTE_W) begin : g_bad_width
      $error("data bus must hold exactly two byte lanes");
   end
   if (RD_CYC < 1 || WR_CYC < 1) begin : g_bad_len
      $error("access lengths must be at least one clock");
   end
   if (RD_CYC > CE_MAX_CYC || WR_CYC > CE_MAX_CYC) begin : g_bad_cem
      $error("access length exceeds the chip-enable low limit");
   end

   logic              load, drop_strb, capture, dq_oe;
   logic [LANES-1:0]  strb_n;
   logic [DATA_W-1:0] wdata_all;
   logic [DATA_W-1:0] rdata_all;
   logic [ADDR_W-1:0] addr_q;

   psram_seq #(
      .RD_CYC     (RD_CYC),
      .WR_CYC     (WR_CYC),
      .CE_MAX_CYC (CE_MAX_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_any   (|req_be),
      .load      (load),
      .drop_strb (drop_strb),
      .capture   (capture),
      .ce_n      (mem_ce_n),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n),
      .dq_oe     (dq_oe),
      .rdy       (rsp_ready)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      psram_lane #(.BYTE_W(BYTE_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load),
         .drop_strb (drop_strb),
         .capture   (capture),
         .sel_in    (req_be[i]),
         .wbyte_in  (req_wdata[i*BYTE_W +: BYTE_W]),
         .dq_in     (mem_dq[i*BYTE_W +: BYTE_W]),
         .strb_n    (strb_n[i]),
         .wbyte     (wdata_all[i*BYTE_W +: BYTE_W]),
         .rbyte     (rdata_all[i*BYTE_W +: BYTE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= req_addr;
   end

   assign mem_lb_n  = strb_n[0];
   assign mem_ub_n  = strb_n[LANES-1];
   assign mem_addr  = addr_q;
   assign rsp_rdata = rdata_all;
   assign mem_dq    = dq_oe ? wdata_all : {DATA_W{1'bz}};

   p_bus_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!dq_oe && !$past(dq_oe)));
   p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> dq_oe);
   p_sel_in_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ub_n || !mem_lb_n) |-> !mem_ce_n);
   p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/tb_psram_async_ctrl.sv
`timescale 1ns/1ps
module tb_psram_async_ctrl;

   localparam int RD  = 4;
   localparam int WR  = 3;
   localparam int CEM = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_we = 1'b0;
   logic [21:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rsp_ready;
   logic [15:0] rsp_rdata;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
   logic [21:0] mem_addr;
   wire  [15:0] mem_dq;

   always #2.5 clk = ~clk;

   psram_async_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
      .mem_lb_n(mem_lb_n), .mem_addr(mem_addr), .mem_dq(mem_dq));

   int n_vec = 0, n_bad = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- memory device model ----------------
   logic [15:0] bmem   [0:255];
   logic [15:0] shadow [0:255];
   int          oe_cnt = 0;
   logic        prev_we_n = 1'b1, prev_ub_n = 1'b1, prev_lb_n = 1'b1;
   logic        bdrv;
   logic [15:0] bdat;

   initial for (int i = 0; i < 256; i++) begin
      bmem[i]   = 16'(i * 16'h0107) ^ 16'h3C3C;
      shadow[i] = 16'(i * 16'h0107) ^ 16'h3C3C;
   end

   assign bdrv   = !mem_ce_n && !mem_oe_n && mem_we_n;
   assign bdat   = (oe_cnt >= RD) ? bmem[mem_addr[7:0]] : 16'hDEAD;
   assign mem_dq = bdrv ? bdat : 16'hzzzz;

   always @(negedge clk) begin
      oe_cnt <= (!mem_ce_n && !mem_oe_n) ? oe_cnt + 1 : 0;
      if (!prev_we_n && mem_we_n) begin
         if (!prev_ub_n) bmem[mem_addr[7:0]][15:8] = mem_dq[15:8];
         if (!prev_lb_n) bmem[mem_addr[7:0]][7:0]  = mem_dq[7:0];
      end
      prev_we_n <= mem_we_n; prev_ub_n <= mem_ub_n; prev_lb_n <= mem_lb_n;
   end

   // ---------------- reference model ----------------
   int          m_t = 0, m_len = 0;
   logic        m_we;
   logic [21:0] m_addr;
   logic [15:0] m_d, m_rd;
   logic [1:0]  m_be;

   always @(posedge clk) begin
      if (!rst_n) m_t = 0;
      else if (m_t == 0) begin
         if (req_valid) begin
            m_we = req_we; m_addr = req_addr; m_d = req_wdata; m_be = req_be;
            m_len = (req_be == 2'b00) ? 2 : (req_we ? WR + 3 : RD + 2);
            if (req_we && req_be[1]) shadow[req_addr[7:0]][15:8] = req_wdata[15:8];
            if (req_we && req_be[0]) shadow[req_addr[7:0]][7:0]  = req_wdata[7:0];
            m_rd = shadow[req_addr[7:0]] & {{8{req_be[1]}}, {8{req_be[0]}}};
            m_t = 1;
         end
      end else begin
         m_t++;
         if (m_t == m_len) m_t = 0;
      end
   end

   int ce_run = 0;
   bit checking = 1'b0;

   always @(negedge clk) begin
      logic e_ce, e_oe, e_we, e_ub, e_lb, e_rdy;
      string tg;
      if (checking) begin
         e_ce = 1; e_oe = 1; e_we = 1; e_ub = 1; e_lb = 1; e_rdy = 0; tg = "R10";
         if (m_t != 0) begin
            if (m_be == 2'b00) begin
               tg = "R8"; e_rdy = (m_t == 1);
            end else if (!m_we) begin
               tg = "R2";
               if (m_t <= RD) begin
                  e_ce = 0; e_oe = 0; e_ub = ~m_be[1]; e_lb = ~m_be[0];
                  chk("R2 addr", 32'(mem_addr), 32'(m_addr));
                  chk("R9 read bus", 32'(mem_dq), 32'(bdat));
               end
               if (m_t == RD + 1) begin
                  e_rdy = 1;
                  chk("R3 R7 rdata", 32'(rsp_rdata), 32'(m_rd));
               end
            end else begin
               tg = "R4";
               if (m_t <= WR) begin
                  e_ce = 0; e_we = 0; e_ub = ~m_be[1]; e_lb = ~m_be[0];
                  chk("R4 addr", 32'(mem_addr), 32'(m_addr));
                  chk("R5 wdata", 32'(mem_dq), 32'(m_d));
               end
               if (m_t == WR + 1) chk("R5 wdata hold", 32'(mem_dq), 32'(m_d));
               if (m_t == WR + 2) e_rdy = 1;
            end
         end
         chk({tg, " ce_n"}, 32'(mem_ce_n), 32'(e_ce));
         chk({tg, " oe_n"}, 32'(mem_oe_n), 32'(e_oe));
         chk({tg, " we_n"}, 32'(mem_we_n), 32'(e_we));
         chk("R7 ub_n", 32'(mem_ub_n), 32'(e_ub));
         chk("R7 lb_n", 32'(mem_lb_n), 32'(e_lb));
         chk({tg, " R10 ready"}, 32'(rsp_ready), 32'(e_rdy));
         ce_run = mem_ce_n ? 0 : ce_run + 1;
         if (!mem_ce_n) chk("R6 ce low run", 32'(ce_run <= CEM), 32'd1);
      end
   end

   // ---------------- stimulus ----------------
   bit done = 1'b0;

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   task automatic issue(input logic we, input logic [21:0] a, input logic [15:0] d,
                        input logic [1:0] be, input bit scramble);
      int w = 0;
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
      do begin
         @(negedge clk);
         w++;
         if (scramble && w == 2) begin   // R10: changes while busy are ignored
            req_we = ~we; req_addr = ~a; req_wdata = ~d; req_be = ~be;
         end
      end while (!rsp_ready && w < 100);
      if (w >= 100) chk("R10 request completes", 32'd0, 32'd1);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 ce_n", 32'(mem_ce_n), 32'd1);
      chk("R1 oe_n", 32'(mem_oe_n), 32'd1);
      chk("R1 we_n", 32'(mem_we_n), 32'd1);
      chk("R1 ub_n lb_n", 32'({mem_ub_n, mem_lb_n}), 32'd3);
      chk("R1 ready", 32'(rsp_ready), 32'd0);
      chk("R1 bus released", 32'(dut.mem_dq === 16'hzzzz || dut.mem_dq === 16'h0000), 32'd1);
      rst_n = 1'b1;
      checking = 1'b1;
      issue(1'b1, 22'd5, 16'hA5C3, 2'b11, 1'b0);
      issue(1'b0, 22'd5, 16'h0000, 2'b11, 1'b0);
      issue(1'b1, 22'd5, 16'h12FF, 2'b10, 1'b0);   // R7 upper lane only
      issue(1'b0, 22'd5, 16'h0000, 2'b01, 1'b0);   // R7 lower lane read
      issue(1'b0, 22'd5, 16'h0000, 2'b10, 1'b0);
      issue(1'b1, 22'd9, 16'h77EE, 2'b01, 1'b0);
      issue(1'b0, 22'd9, 16'h0000, 2'b11, 1'b0);
      issue(1'b0, 22'd5, 16'h0000, 2'b00, 1'b0);   // R8 empty read
      issue(1'b1, 22'd5, 16'hFFFF, 2'b00, 1'b0);   // R8 empty write
      issue(1'b0, 22'd5, 16'h0000, 2'b11, 1'b0);   // R8 contents unchanged
      issue(1'b0, 22'd9, 16'h0000, 2'b11, 1'b1);   // R10 scrambled while busy
      issue(1'b1, 22'h3FFFFF, 16'hBEEF, 2'b11, 1'b1);
      issue(1'b0, 22'h3FFFFF, 16'h0000, 2'b11, 1'b0);
      issue(1'b0, 22'd5, 16'h0000, 2'b11, 1'b0);
      repeat (4) @(negedge clk);
      chk("R1 R10 idle after run", 32'({mem_ce_n, mem_oe_n, mem_we_n}), 32'd7);
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk("R10 watchdog", 32'd0, 32'd1);
         finish_run();
      end
   end

endmodule